// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block turns GPIO input activity into four interrupt requests, channels A, B, C and D. Channels A and B always watch fixed bits of the GPIO input bus, set by parameters. Channels C and D each take their source bit from a select register. Each channel has a programmable trigger condition and an optional glitch filter. It also holds a pending flag, which software clears by writing a one to it. The block taps the synchronized input value of the bus, so a pin driven as an output by its pad can still raise an interrupt.

Software reaches the block through a small register port. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. Register map (8-bit data):

- Addresses 0 to 3 hold the channel configuration for A to D. Bits [2:0] are the trigger mode and bit 3 enables the filter.
- Address 4 holds the channel C pin select in bits [4:0].
- Address 5 holds the channel D pin select in bits [4:0].
- Address 6 holds the pending flags. Bit n belongs to channel n, where A = 0 and D = 3.

Unused bits read as zero. Address 7 reads zero and ignores writes.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `flags` and `irq` are all low.
- R2: Mode 1 sets the channel flag on a 0-to-1 change of its observed input. Mode 2 sets it on a 1-to-0 change. Mode 3 sets it on either change.
- R3: Mode 4 sets the flag while the observed input is 1, and mode 5 sets it while the input is 0. If a clear is written while the level is still active, the flag reads 0 for one cycle and then sets again on the next cycle.
- R4: Writing address 6 clears each flag whose data bit is 1. Bits written as 0 leave their flags unchanged. An edge event that arrives in the same cycle as a clear still sets the flag.
- R5: Modes 0, 6 and 7 never set a flag. Switching a channel into an edge mode while its input is steady does not set the flag.
- R6: `irq[n]` is high exactly when `flags[n]` is set and the channel mode is 1 to 5. Moving to mode 0 drops `irq` but keeps the flag.
- R7: A select code k picks `gpio_in[k]`, with k = port*8 + bit (for example, 9 picks port B bit 1). Codes at or above the bus width give a constant 0. Activity on pins that are not selected has no effect.
- R8: Channels A and B use `gpio_in[FIX_A]` and `gpio_in[FIX_B]` (defaults 4 and 5) and have no select register.
- R9: With the filter off, a change on a GPIO pin passes through two synchronizer stages. An edge driven before clock edge 1 shows in `flags` after edge 3.
- R10: With the filter on, the observed input takes a new value only after the synchronized pin has differed from it for FILT_CYC consecutive clocks (default 90, about 450 ns at 200 MHz). Shorter pulses are dropped, and a held step shows in `flags` after edge FILT_CYC+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | GPIO_W | GPIO input bus, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| flags | output | 4 | Pending flags, channel A at bit 0 |
| irq | output | 4 | Interrupt request lines, channel A at bit 0 |

## Verification
The bound checker watches every cycle for four things. An edge event or an uncleared active level must be followed by a set flag. A written one must drop a flag that no edge is re-setting. A flag must hold until it is cleared. A disabled mode must never raise a flag, and no request may appear without its flag. The exact pin mapping of the select codes, the synchronizer latency and the filter's hold window are end-to-end timings. Only the bench scenarios and its cycle-by-cycle reference model can show these, with directed pulses on chosen pins.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_SEL_C = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SEL_D = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd6;

  localparam logic [MODE_W-1:0] MODE_OFF  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_RISE = 3'd1;
  localparam logic [MODE_W-1:0] MODE_FALL = 3'd2;
  localparam logic [MODE_W-1:0] MODE_BOTH = 3'd3;
  localparam logic [MODE_W-1:0] MODE_HIGH = 3'd4;
  localparam logic [MODE_W-1:0] MODE_LOW  = 3'd5;

  // a mode code that arms the channel
  function automatic logic mode_armed(input logic [MODE_W-1:0] m);
    return (m >= MODE_RISE) && (m <= MODE_LOW);
  endfunction

  // edge condition for the current and previous observed value
  function automatic logic edge_seen(input logic [MODE_W-1:0] m, input logic cur, input logic prv);
    case (m)
      MODE_RISE: return cur & ~prv;
      MODE_FALL: return ~cur & prv;
      MODE_BOTH: return cur ^ prv;
      default:   return 1'b0;
    endcase
  endfunction

  // level condition for the current observed value
  function automatic logic level_seen(input logic [MODE_W-1:0] m, input logic cur);
    case (m)
      MODE_HIGH: return cur;
      MODE_LOW:  return ~cur;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/extirq_filter.sv
module extirq_filter #(
  parameter int HOLD_CYC = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] run_q;
  logic             val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      val_q <= 1'b0;
    end else if (din == val_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q <= '0;
      val_q <= din;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = val_q;
endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
  import extirq_pkg::*;
#(
  parameter int FILT_CYC = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src,
  input  logic [MODE_W-1:0] mode,
  input  logic              filt_en,
  input  logic              clr,
  output logic              flag,
  output logic              irq,
  output logic              mode_ok,
  output logic              edge_evt,
  output logic              lvl_evt
);
  logic filt_val;
  logic cur;
  logic prev_q;
  logic flag_q;
  logic flag_d;

  extirq_filter #(.HOLD_CYC(FILT_CYC)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (src),
    .dout (filt_val)
  );

  assign cur      = filt_en ? filt_val : src;
  assign mode_ok  = mode_armed(mode);
  assign edge_evt = edge_seen(mode, cur, prev_q);
  assign lvl_evt  = level_seen(mode, cur);

  // edges win over a clear; levels are masked for the clear cycle only
  assign flag_d = edge_evt | (~clr & (lvl_evt | flag_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= cur;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & mode_ok;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int GPIO_W   = 24,
  parameter int SEL_W    = 5,
  parameter int FIX_A    = 4,
  parameter int FIX_B    = 5,
  parameter int FILT_CYC = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] irq
);
  localparam int CFG_W = MODE_W + 1;

  logic [GPIO_W-1:0] gpio_s;
  logic [CFG_W-1:0]  cfg_q [NUM_CH];
  logic [SEL_W-1:0]  sel_c_q;
  logic [SEL_W-1:0]  sel_d_q;
  logic [NUM_CH-1:0] src;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] mode_ok;
  logic [NUM_CH-1:0] edge_evt;
  logic [NUM_CH-1:0] lvl_evt;

  function automatic logic pick(input logic [GPIO_W-1:0] v, input logic [SEL_W-1:0] k);
    return (32'(k) < GPIO_W) ? v[k] : 1'b0;
  endfunction

  extirq_sync #(.W(GPIO_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (gpio_in),
    .dout (gpio_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
      sel_c_q <= '0;
      sel_d_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CH; i++)
        if (wr_addr == ADDR_W'(i)) cfg_q[i] <= wr_data[CFG_W-1:0];
      if (wr_addr == ADDR_SEL_C) sel_c_q <= wr_data[SEL_W-1:0];
      if (wr_addr == ADDR_SEL_D) sel_d_q <= wr_data[SEL_W-1:0];
    end
  end

  assign clr_vec = (wr_en && wr_addr == ADDR_FLAGS) ? wr_data[NUM_CH-1:0] : '0;

  assign src[0] = gpio_s[FIX_A];
  assign src[1] = gpio_s[FIX_B];
  assign src[2] = pick(gpio_s, sel_c_q);
  assign src[3] = pick(gpio_s, sel_d_q);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    extirq_chan #(.FILT_CYC(FILT_CYC)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src[c]),
      .mode    (cfg_q[c][MODE_W-1:0]),
      .filt_en (cfg_q[c][MODE_W]),
      .clr     (clr_vec[c]),
      .flag    (flags[c]),
      .irq     (irq[c]),
      .mode_ok (mode_ok[c]),
      .edge_evt(edge_evt[c]),
      .lvl_evt (lvl_evt[c])
    );
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      3'd0, 3'd1, 3'd2, 3'd3: rd_data = DATA_W'(cfg_q[rd_addr[1:0]]);
      ADDR_SEL_C:             rd_data = DATA_W'(sel_c_q);
      ADDR_SEL_D:             rd_data = DATA_W'(sel_d_q);
      ADDR_FLAGS:             rd_data = DATA_W'(flags);
      default:                rd_data = '0;
    endcase
  end
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk
  import extirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] mode_ok,
  input logic [NUM_CH-1:0] edge_evt,
  input logic [NUM_CH-1:0] lvl_evt
);
  logic [NUM_CH-1:0] clr;
  assign clr = (wr_en && wr_addr == ADDR_FLAGS) ? wr_data[NUM_CH-1:0] : '0;

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flags) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[c] |=> flags[c]);
    // R3
    level_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_evt[c] && !clr[c]) |=> flags[c]);
    // R4
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && !edge_evt[c]) |=> !flags[c]);
    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[c] && !clr[c]) |=> flags[c]);
    // R5
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ok[c] |=> !$rose(flags[c]));
  end
endmodule

bind extirq_ctrl extirq_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .flags   (flags),
  .irq     (irq),
  .mode_ok (mode_ok),
  .edge_evt(edge_evt),
  .lvl_evt (lvl_evt)
);

// File: tb/extirq_ctrl_test.sv
`timescale 1ns/1ps
module extirq_ctrl_test;
  localparam int GW = 24;
  localparam int FC = 90;
  localparam int FA = 4;
  localparam int FB = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [GW-1:0] gpio = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [2:0]    rd_addr = 3'd6;
  logic [7:0]    rd_data;
  logic [3:0]    flags;
  logic [3:0]    irq;

  always #2.5 clk = ~clk;

  extirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .flags(flags), .irq(irq)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [GW-1:0] m_s1 = '0, m_s2 = '0;
  logic [3:0]    m_cfg [4] = '{default: '0};
  logic [4:0]    m_selc = '0, m_seld = '0;
  logic [3:0]    m_flag = '0;
  logic [3:0]    m_fv = '0;
  int            m_cnt [4] = '{default: 0};
  logic [3:0]    m_prev = '0;
  logic [3:0]    nf;

  function automatic logic bit_of(input logic [GW-1:0] v, input int k);
    if (k < GW) return v[k];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_selc = '0; m_seld = '0; m_flag = '0; m_fv = '0; m_prev = '0;
      for (int c = 0; c < 4; c++) begin m_cfg[c] = '0; m_cnt[c] = 0; end
    end else begin
      for (int c = 0; c < 4; c++) begin
        logic s, v, e, lv, cl;
        int md;
        s  = (c == 0) ? m_s2[FA] : (c == 1) ? m_s2[FB] :
             (c == 2) ? bit_of(m_s2, int'(m_selc)) : bit_of(m_s2, int'(m_seld));
        v  = m_cfg[c][3] ? m_fv[c] : s;
        md = int'(m_cfg[c][2:0]);
        e  = (md == 1 && v && !m_prev[c]) || (md == 2 && !v && m_prev[c]) ||
             (md == 3 && v != m_prev[c]);
        lv = (md == 4 && v) || (md == 5 && !v);
        cl = wr_en && wr_addr == 3'd6 && wr_data[c];
        nf[c] = e || (!cl && (lv || m_flag[c]));
        m_prev[c] = v;
        if (s == m_fv[c]) m_cnt[c] = 0;
        else if (m_cnt[c] + 1 == FC) begin m_cnt[c] = 0; m_fv[c] = s; end
        else m_cnt[c] = m_cnt[c] + 1;
      end
      m_flag = nf;
      if (wr_en) begin
        if (wr_addr < 3'd4) m_cfg[wr_addr[1:0]] = wr_data[3:0];
        if (wr_addr == 3'd4) m_selc = wr_data[4:0];
        if (wr_addr == 3'd5) m_seld = wr_data[4:0];
      end
      m_s2 = m_s1;
      m_s1 = gpio;
    end
  end

  function automatic logic [7:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2, 3'd3: return {4'b0, m_cfg[a[1:0]]};
      3'd4: return {3'b0, m_selc};
      3'd5: return {3'b0, m_seld};
      3'd6: return {4'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] m_irq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = m_flag[c] && m_cfg[c][2:0] >= 3'd1 && m_cfg[c][2:0] <= 3'd5;
    return r;
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, "model flags", int'(flags), int'(m_flag));
      chk(cur_req, "model irq", int'(irq), int'(m_irq()));
      chk(cur_req, "model rd_data", int'(rd_data), int'(m_rd(rd_addr)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pin(input int k, input logic v);
    @(negedge clk);
    gpio[k] = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin
      @(negedge clk) rd_addr = 3'(a);
      step(1);
      chk("R1", "reset readback", int'(rd_data), 0);
    end
    chk("R1", "reset flags", int'(flags), 0);
    chk("R1", "reset irq", int'(irq), 0);
    @(negedge clk) rd_addr = 3'd6;

    cur_req = "R9";
    wr(3'd0, 8'h01);
    pin(FA, 1'b1);
    step(2);
    chk("R9", "flag A before third edge", int'(flags[0]), 0);
    step(1);
    chk("R9", "flag A after third edge", int'(flags[0]), 1);
    chk("R6", "irq A with flag", int'(irq[0]), 1);
    chk("R8", "channel B untouched", int'(flags[1]), 0);

    cur_req = "R4";
    wr(3'd6, 8'h00);
    chk("R4", "write 0 keeps flag", int'(flags[0]), 1);
    wr(3'd6, 8'h01);
    chk("R4", "write 1 clears flag", int'(flags[0]), 0);

    cur_req = "R2";
    wr(3'd1, 8'h02);
    pin(FB, 1'b1);
    step(5);
    chk("R2", "fall mode ignores rise", int'(flags[1]), 0);
    pin(FB, 1'b0);
    step(3);
    chk("R2", "fall mode sets", int'(flags[1]), 1);
    wr(3'd6, 8'h02);
    wr(3'd0, 8'h03);
    pin(FA, 1'b0);
    step(3);
    chk("R2", "both mode on fall", int'(flags[0]), 1);
    wr(3'd6, 8'h01);
    pin(FA, 1'b1);
    step(3);
    chk("R2", "both mode on rise", int'(flags[0]), 1);
    wr(3'd6, 8'h01);

    cur_req = "R3";
    wr(3'd0, 8'h04);
    step(1);
    chk("R3", "high level sets", int'(flags[0]), 1);
    wr(3'd6, 8'h01);
    chk("R3", "clear cycle low", int'(flags[0]), 0);
    step(1);
    chk("R3", "level re-sets", int'(flags[0]), 1);
    wr(3'd0, 8'h05);
    wr(3'd6, 8'h01);
    step(2);
    chk("R3", "low level idle while high", int'(flags[0]), 0);
    pin(FA, 1'b0);
    step(3);
    chk("R3", "low level sets", int'(flags[0]), 1);

    cur_req = "R6";
    wr(3'd0, 8'h00);
    chk("R6", "mode off drops irq", int'(irq[0]), 0);
    chk("R6", "mode off keeps flag", int'(flags[0]), 1);
    wr(3'd6, 8'h01);

    cur_req = "R5";
    pin(FA, 1'b1);
    step(4);
    chk("R5", "mode 0 quiet", int'(flags[0]), 0);
    wr(3'd0, 8'h06);
    pin(FA, 1'b0);
    step(4);
    chk("R5", "mode 6 quiet", int'(flags[0]), 0);
    wr(3'd0, 8'h07);
    pin(FA, 1'b1);
    step(4);
    chk("R5", "mode 7 quiet", int'(flags[0]), 0);
    wr(3'd0, 8'h01);
    step(4);
    chk("R5", "mode switch alone", int'(flags[0]), 0);

    cur_req = "R7";
    wr(3'd4, 8'd9);
    wr(3'd2, 8'h01);
    wr(3'd5, 8'd17);
    wr(3'd3, 8'h02);
    pin(10, 1'b1);
    step(4);
    chk("R7", "unselected pin ignored", int'(flags[2]), 0);
    pin(9, 1'b1);
    step(3);
    chk("R7", "code 9 picks port B bit 1", int'(flags[2]), 1);
    pin(17, 1'b1);
    step(4);
    chk("R7", "D fall ignores rise", int'(flags[3]), 0);
    pin(17, 1'b0);
    step(3);
    chk("R7", "code 17 picks port C bit 1", int'(flags[3]), 1);
    wr(3'd6, 8'h0C);
    wr(3'd5, 8'd25);
    wr(3'd3, 8'h03);
    @(negedge clk) gpio = ~gpio;
    step(4);
    chk("R7", "out-of-range code is constant", int'(flags[3]), 0);

    cur_req = "R10";
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00);
    @(negedge clk) gpio = '0;
    step(FC + 10);
    wr(3'd6, 8'h0F);
    wr(3'd4, 8'd3);
    wr(3'd2, 8'h09);
    step(2);
    pin(3, 1'b1);
    step(FC / 2);
    pin(3, 1'b0);
    step(FC + 10);
    chk("R10", "short pulse dropped", int'(flags[2]), 0);
    pin(3, 1'b1);
    step(FC + 2);
    chk("R10", "held step not yet seen", int'(flags[2]), 0);
    step(1);
    chk("R10", "held step after window", int'(flags[2]), 1);

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int b = 0; b < GW; b++) if ($urandom_range(15) == 0) gpio[b] = ~gpio[b];
      wr_en = ($urandom_range(7) == 0);
      wr_addr = 3'($urandom_range(7));
      wr_data = 8'($urandom_range(255));
      if (wr_addr == 3'd4 || wr_addr == 3'd5) wr_data = 8'($urandom_range(27));
      if (i % 97 == 0) rd_addr = 3'($urandom_range(7));
    end
    @(negedge clk) wr_en = 1'b0;
    step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog run did not finish got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule